// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-facing register bank of a 64-channel DMA controller. It keeps four per-channel bitmaps: request enable, error-interrupt enable, interrupt pending and error pending. Each is seen by software as two 32-bit words, one for the upper 32 channels and one for the lower 32. Software changes a single channel's bit without a read-modify-write cycle: it writes the channel number into a dedicated byte-wide command slot. The channel engines report completion and errors on per-channel set vectors.

The bank also keeps a control word for the clock-gating and arbitration mode bits. It records the first error reported by the engines, with the channel number and the cause bits, in a status word. It merges pending interrupts and enabled errors into one interrupt line. On command it emits a one-cycle start pulse toward a single channel. Reads are combinational on the address. Writes take effect on the next rising clock edge.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, every bitmap, the control word and the error status word read 0, `irq_o` is low and `start_o` is all zero.
- R2: The control word at 0x00 stores only bit 31 (clock gating enable, `clk_gate_en_o`), bit 3 (round-robin group arbitration, `rr_group_o`) and bit 2 (round-robin channel arbitration, `rr_chan_o`). Its other bits read 0.
- R3: The request-enable bitmap can be written and read as whole words: 0x08 holds channels 63..32, with channel k at bit k-32, and 0x0C holds channels 31..0. The error-interrupt-enable bitmap uses 0x10 (high) and 0x14 (low) in the same way. `req_en_o[k]` shows channel k's request-enable bit.
- R4: Word 0x18 holds four command bytes, each taking a channel number: lane 3 (bits 31:24) sets a request-enable bit, lane 2 (23:16) clears one, lane 1 (15:8) sets an error-interrupt-enable bit and lane 0 (7:0) clears one. A lane acts only when its `be_i` bit is set. When the set and clear lanes of one bitmap name the same channel in the same write, the clear wins.
- R5: A command byte with a value of 64 or more has no effect on any bitmap or on `start_o`.
- R6: `int_set_i[k]` and `err_set_i[k]` set the pending bits. The pending words are write-one-to-clear: 0x20 and 0x24 for interrupts (high, low), 0x28 and 0x2C for errors (high, low). In word 0x1C, lane 3 clears one interrupt-pending bit by channel number and lane 2 clears one error-pending bit. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R7: `irq_o` is high while any interrupt-pending bit is set, or while an error-pending bit is set whose error-interrupt-enable bit is also set.
- R8: When `err_ev_i` is high and no error is held, the status word at 0x04 captures the error. Bit 31 is the valid flag. Bits 13:8 hold `err_chan_i`. Bits 15 and 14 hold `err_cause_i[9:8]` (group and channel priority errors). Bits 7:0 hold `err_cause_i[7:0]` (source address, source offset, destination address, destination offset, count configuration, chain configuration, source bus and destination bus errors, from bit 7 down to bit 0).
- R9: A held error status stays unchanged until the error-pending bit of the recorded channel is cleared, by a write-one-to-clear or by the clear-by-number command. It then reads 0. If a new error is reported in the cycle of that clear, the new error is captured.
- R10: Writing channel k (0..63) to lane 1 of word 0x1C raises `start_o[k]` for exactly one cycle, the cycle after the write.
- R11: Words 0x30 (high) and 0x34 (low) read the live `hw_req_i` vector. The command words and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte address of the word accessed |
| be_i | input | 4 | Byte lane enables, used by the command words |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| hw_req_i | input | 64 | Live hardware request status per channel |
| int_set_i | input | 64 | Per-channel completion events from the engines |
| err_set_i | input | 64 | Per-channel error events from the engines |
| err_ev_i | input | 1 | Error report valid |
| err_chan_i | input | 6 | Channel of the reported error |
| err_cause_i | input | 10 | Cause bits of the reported error |
| clk_gate_en_o | output | 1 | Clock gating enable |
| rr_group_o | output | 1 | Round-robin group arbitration |
| rr_chan_o | output | 1 | Round-robin channel arbitration |
| req_en_o | output | 64 | Request enable per channel |
| start_o | output | 64 | One-cycle start pulse per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two pairs of actions can fall in the same cycle. An engine may set a pending bit in the cycle software clears that bit. Software may clear the failing channel's error bit in the cycle an engine reports a new error. The bench drives each pair in one cycle: a write-one-to-clear word or a clear command on the same port cycle as `int_set_i`, `err_set_i` or `err_ev_i`. The pending bit must stay set, and the status word must show the new error rather than 0. A behavioural model applies the same ordering rules, and its bitmaps, outputs and read words are compared with the design every cycle and at every read.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int unsigned CH_N  = 64;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 8;
  localparam int unsigned IDX_W = $clog2(CH_N);
  localparam int unsigned CAU_W = 10;
  localparam int unsigned NCMD  = 7;

  localparam logic [AW-1:0] A_CTRL   = 8'h00;
  localparam logic [AW-1:0] A_ESTAT  = 8'h04;
  localparam logic [AW-1:0] A_REN_HI = 8'h08;
  localparam logic [AW-1:0] A_REN_LO = 8'h0C;
  localparam logic [AW-1:0] A_EIE_HI = 8'h10;
  localparam logic [AW-1:0] A_EIE_LO = 8'h14;
  localparam logic [AW-1:0] A_CMD0   = 8'h18;
  localparam logic [AW-1:0] A_CMD1   = 8'h1C;
  localparam logic [AW-1:0] A_INT_HI = 8'h20;
  localparam logic [AW-1:0] A_INT_LO = 8'h24;
  localparam logic [AW-1:0] A_ERR_HI = 8'h28;
  localparam logic [AW-1:0] A_ERR_LO = 8'h2C;
  localparam logic [AW-1:0] A_HRQ_HI = 8'h30;
  localparam logic [AW-1:0] A_HRQ_LO = 8'h34;

  localparam logic [DW-1:0] CTRL_MASK = 32'h8000_000C;

  // command slot order: ren set/clr, eie set/clr, int clr, err clr, start
  typedef enum logic [2:0] {
    C_REN_SET, C_REN_CLR, C_EIE_SET, C_EIE_CLR, C_INT_CLR, C_ERR_CLR, C_START
  } cmd_e;
endpackage

// File: rtl/dma_idx_dec.sv
module dma_idx_dec #(
  parameter int unsigned CH_N = 64,
  parameter int unsigned BW   = 8
) (
  input  logic            en_i,
  input  logic [BW-1:0]   idx_i,
  output logic [CH_N-1:0] vec_o
);
  // values >= CH_N match nothing
  always_comb begin
    vec_o = '0;
    for (int k = 0; k < CH_N; k++)
      if (en_i && idx_i == BW'(k)) vec_o[k] = 1'b1;
  end
endmodule

// File: rtl/dma_bitmap.sv
module dma_bitmap #(
  parameter int unsigned CH_N = 64,
  parameter int unsigned DW   = 32,
  parameter bit          W1C  = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_hi_i,
  input  logic            wr_lo_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [CH_N-1:0] set_i,
  input  logic [CH_N-1:0] clr_i,
  output logic [CH_N-1:0] q_o,
  output logic [CH_N-1:0] clr_o
);
  logic [CH_N-1:0] d;

  if (W1C) begin : g_w1c
    logic [CH_N-1:0] word_m;
    assign word_m = {wr_hi_i ? wdata_i : '0, wr_lo_i ? wdata_i : '0};
    assign clr_o  = clr_i | word_m;
    assign d      = (q_o & ~clr_o) | set_i;  // engine event wins

    a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
  end else begin : g_rw
    logic [CH_N-1:0] ld;
    assign ld    = {wr_hi_i ? wdata_i : q_o[CH_N-1:DW], wr_lo_i ? wdata_i : q_o[DW-1:0]};
    assign clr_o = clr_i;
    assign d     = (ld | set_i) & ~clr_i;   // clear wins

    a_r4_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i != '0) |=> ((q_o & $past(clr_i)) == '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
endmodule

// File: rtl/dma_err_latch.sv
module dma_err_latch #(
  parameter int unsigned CH_N  = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CAU_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_i,
  input  logic [IDX_W-1:0] chan_i,
  input  logic [CAU_W-1:0] cause_i,
  input  logic [CH_N-1:0]  clr_vec_i,
  output logic [DW-1:0]    stat_o
);
  logic             valid_q;
  logic [IDX_W-1:0] chan_q;
  logic [CAU_W-1:0] cause_q;
  logic             hold;

  assign hold = valid_q && !clr_vec_i[chan_q];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_q <= 1'b0;
      chan_q  <= '0;
      cause_q <= '0;
    end else if (!hold) begin
      valid_q <= ev_i;
      chan_q  <= ev_i ? chan_i  : '0;
      cause_q <= ev_i ? cause_i : '0;
    end

  always_comb begin
    stat_o        = '0;
    stat_o[31]    = valid_q;
    stat_o[15:14] = cause_q[9:8];
    stat_o[13:8]  = chan_q;
    stat_o[7:0]   = cause_q[7:0];
  end

  a_r9_first_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !clr_vec_i[chan_q]) |=> $stable(stat_o));
  a_r8_valid_from_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[31]) |-> $past(ev_i));
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int unsigned P_CH_N  = CH_N,
  parameter int unsigned P_DW    = DW,
  parameter int unsigned P_AW    = AW,
  parameter int unsigned P_CAU_W = CAU_W,
  localparam int unsigned P_IDX_W = $clog2(P_CH_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [P_AW-1:0]    addr_i,
  input  logic [3:0]         be_i,
  input  logic [P_DW-1:0]    wdata_i,
  output logic [P_DW-1:0]    rdata_o,
  input  logic [P_CH_N-1:0]  hw_req_i,
  input  logic [P_CH_N-1:0]  int_set_i,
  input  logic [P_CH_N-1:0]  err_set_i,
  input  logic               err_ev_i,
  input  logic [P_IDX_W-1:0] err_chan_i,
  input  logic [P_CAU_W-1:0] err_cause_i,
  output logic               clk_gate_en_o,
  output logic               rr_group_o,
  output logic               rr_chan_o,
  output logic [P_CH_N-1:0]  req_en_o,
  output logic [P_CH_N-1:0]  start_o,
  output logic               irq_o
);
  localparam int unsigned HI = P_CH_N - 1;

  logic [P_CH_N-1:0] cmd_vec [NCMD];
  logic [P_DW-1:0]   ctrl_q, stat;
  logic [P_CH_N-1:0] eie_q, int_q, err_q, err_clr, ren_clr_unused, eie_clr_unused, int_clr_unused;

  function automatic logic wr_at(input logic [P_AW-1:0] a);
    return wr_i && addr_i == a;
  endfunction

  for (genvar s = 0; s < NCMD; s++) begin : g_cmd
    localparam int unsigned    LN = 3 - (s % 4);
    localparam logic [P_AW-1:0] CA = (s < 4) ? A_CMD0 : A_CMD1;
    dma_idx_dec #(.CH_N(P_CH_N), .BW(8)) u_dec (
      .en_i (wr_at(CA) && be_i[LN]),
      .idx_i(wdata_i[8*LN +: 8]),
      .vec_o(cmd_vec[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctrl_q  <= '0;
      start_o <= '0;
    end else begin
      if (wr_at(A_CTRL)) ctrl_q <= wdata_i & CTRL_MASK;
      start_o <= cmd_vec[C_START];
    end

  assign clk_gate_en_o = ctrl_q[31];
  assign rr_group_o    = ctrl_q[3];
  assign rr_chan_o     = ctrl_q[2];

  dma_bitmap #(.CH_N(P_CH_N), .DW(P_DW), .W1C(1'b0)) u_ren (
    .clk_i, .rst_ni, .wr_hi_i(wr_at(A_REN_HI)), .wr_lo_i(wr_at(A_REN_LO)), .wdata_i,
    .set_i(cmd_vec[C_REN_SET]), .clr_i(cmd_vec[C_REN_CLR]), .q_o(req_en_o), .clr_o(ren_clr_unused));

  dma_bitmap #(.CH_N(P_CH_N), .DW(P_DW), .W1C(1'b0)) u_eie (
    .clk_i, .rst_ni, .wr_hi_i(wr_at(A_EIE_HI)), .wr_lo_i(wr_at(A_EIE_LO)), .wdata_i,
    .set_i(cmd_vec[C_EIE_SET]), .clr_i(cmd_vec[C_EIE_CLR]), .q_o(eie_q), .clr_o(eie_clr_unused));

  dma_bitmap #(.CH_N(P_CH_N), .DW(P_DW), .W1C(1'b1)) u_int (
    .clk_i, .rst_ni, .wr_hi_i(wr_at(A_INT_HI)), .wr_lo_i(wr_at(A_INT_LO)), .wdata_i,
    .set_i(int_set_i), .clr_i(cmd_vec[C_INT_CLR]), .q_o(int_q), .clr_o(int_clr_unused));

  dma_bitmap #(.CH_N(P_CH_N), .DW(P_DW), .W1C(1'b1)) u_err (
    .clk_i, .rst_ni, .wr_hi_i(wr_at(A_ERR_HI)), .wr_lo_i(wr_at(A_ERR_LO)), .wdata_i,
    .set_i(err_set_i), .clr_i(cmd_vec[C_ERR_CLR]), .q_o(err_q), .clr_o(err_clr));

  dma_err_latch #(.CH_N(P_CH_N), .DW(P_DW), .IDX_W(P_IDX_W), .CAU_W(P_CAU_W)) u_elat (
    .clk_i, .rst_ni, .ev_i(err_ev_i), .chan_i(err_chan_i), .cause_i(err_cause_i),
    .clr_vec_i(err_clr), .stat_o(stat));

  assign irq_o = (|int_q) || (|(err_q & eie_q));

  always_comb begin
    unique case (addr_i)
      A_CTRL:   rdata_o = ctrl_q;
      A_ESTAT:  rdata_o = stat;
      A_REN_HI: rdata_o = req_en_o[HI:P_DW];
      A_REN_LO: rdata_o = req_en_o[P_DW-1:0];
      A_EIE_HI: rdata_o = eie_q[HI:P_DW];
      A_EIE_LO: rdata_o = eie_q[P_DW-1:0];
      A_INT_HI: rdata_o = int_q[HI:P_DW];
      A_INT_LO: rdata_o = int_q[P_DW-1:0];
      A_ERR_HI: rdata_o = err_q[HI:P_DW];
      A_ERR_LO: rdata_o = err_q[P_DW-1:0];
      A_HRQ_HI: rdata_o = hw_req_i[HI:P_DW];
      A_HRQ_LO: rdata_o = hw_req_i[P_DW-1:0];
      default:  rdata_o = '0;
    endcase
  end

  a_r10_start_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o));
  a_r10_start_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o != '0) |-> $past(wr_i && addr_i == A_CMD1 && be_i[1]));
  a_r7_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(int_set_i != '0 || err_set_i != '0 || wr_i));
endmodule

// File: tb/dma_ctl_regs_test.sv
module dma_ctl_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] hw_req_i = '0, int_set_i = '0, err_set_i = '0;
  logic        err_ev_i = 1'b0;
  logic [5:0]  err_chan_i = '0;
  logic [9:0]  err_cause_i = '0;
  logic        clk_gate_en_o, rr_group_o, rr_chan_o, irq_o;
  logic [63:0] req_en_o, start_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  dma_ctl_regs uut (.*);

  int errors = 0, checks = 0;
  bit done_run = 0;

  // reference model state
  bit [31:0] m_ctrl;
  bit [63:0] m_ren, m_eie, m_int, m_err, m_start;
  bit        m_valid;
  int        m_chan;
  bit [9:0]  m_cause;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit [63:0] cmd(input bit [7:0] a, input int lane);
    bit [63:0] v = '0;
    int idx = wdata_i[8*lane +: 8];
    if (wr_i && addr_i == a && be_i[lane] && idx < 64) v[idx] = 1'b1;
    return v;
  endfunction

  function automatic bit [63:0] w1c(input bit [7:0] ahi, input bit [7:0] alo);
    bit [63:0] m = '0;
    if (wr_i && addr_i == ahi) m[63:32] = wdata_i;
    if (wr_i && addr_i == alo) m[31:0]  = wdata_i;
    return m;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 0; m_ren = 0; m_eie = 0; m_int = 0; m_err = 0; m_start = 0;
      m_valid = 0; m_chan = 0; m_cause = 0;
    end else begin
      bit [63:0] clr_e;
      bit hold;
      clr_e = cmd(8'h1C, 2) | w1c(8'h28, 8'h2C);
      hold  = m_valid && !clr_e[m_chan];
      m_start = cmd(8'h1C, 1);
      if (wr_i && addr_i == 8'h00) m_ctrl = wdata_i & 32'h8000_000C;
      if (wr_i && addr_i == 8'h08) m_ren[63:32] = wdata_i;
      if (wr_i && addr_i == 8'h0C) m_ren[31:0]  = wdata_i;
      m_ren = (m_ren | cmd(8'h18, 3)) & ~cmd(8'h18, 2);
      if (wr_i && addr_i == 8'h10) m_eie[63:32] = wdata_i;
      if (wr_i && addr_i == 8'h14) m_eie[31:0]  = wdata_i;
      m_eie = (m_eie | cmd(8'h18, 1)) & ~cmd(8'h18, 0);
      m_int = (m_int & ~(cmd(8'h1C, 3) | w1c(8'h20, 8'h24))) | int_set_i;
      m_err = (m_err & ~clr_e) | err_set_i;
      if (!hold) begin
        m_valid = err_ev_i;
        m_chan  = err_ev_i ? int'(err_chan_i) : 0;
        m_cause = err_ev_i ? err_cause_i : '0;
      end
    end
  end

  function automatic bit [31:0] m_rd(input bit [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return {m_valid, 15'b0, m_cause[9:8], 6'(m_chan), m_cause[7:0]};
      8'h08: return m_ren[63:32];
      8'h0C: return m_ren[31:0];
      8'h10: return m_eie[63:32];
      8'h14: return m_eie[31:0];
      8'h20: return m_int[63:32];
      8'h24: return m_int[31:0];
      8'h28: return m_err[63:32];
      8'h2C: return m_err[31:0];
      8'h30: return hw_req_i[63:32];
      8'h34: return hw_req_i[31:0];
      default: return 32'h0;
    endcase
  endfunction

  // per-cycle compare against the model
  always @(negedge clk_i) if (rst_ni && !done_run) begin
    chk("R7 irq_o", 64'(irq_o), 64'((|m_int) || (|(m_err & m_eie))));
    chk("R10 start_o", start_o, m_start);
    chk("R3 req_en_o", req_en_o, m_ren);
    chk("R2 ctrl outs", 64'({clk_gate_en_o, rr_group_o, rr_chan_o}),
        64'({m_ctrl[31], m_ctrl[3], m_ctrl[2]}));
  end

  task automatic cyc(input bit w, input bit [7:0] a, input bit [31:0] d, input bit [3:0] b,
                     input bit [63:0] iset, input bit [63:0] eset,
                     input bit ev, input bit [5:0] ch, input bit [9:0] cs);
    @(negedge clk_i); #1;
    wr_i = w; addr_i = a; wdata_i = d; be_i = b;
    int_set_i = iset; err_set_i = eset; err_ev_i = ev; err_chan_i = ch; err_cause_i = cs;
    @(negedge clk_i); #1;
    wr_i = 0; be_i = 0; int_set_i = 0; err_set_i = 0; err_ev_i = 0;
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d, input bit [3:0] b = 4'hF);
    cyc(1, a, d, b, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input string tag, input bit [7:0] a, input bit [31:0] exp);
    @(negedge clk_i); #1;
    addr_i = a; #1;
    chk(tag, 64'(rdata_o), 64'(exp));
  endtask

  initial begin
    #(20 * 100000);
    if (!done_run) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    for (int a = 0; a < 'h38; a += 4) rd("R1 reset read", 8'(a), 32'h0);
    chk("R1 irq after reset", 64'(irq_o), 0);
    chk("R1 start after reset", start_o, 0);

    // R2 control word
    wr(8'h00, 32'hFFFF_FFFF);
    rd("R2 ctrl mask", 8'h00, 32'h8000_000C);
    wr(8'h00, 32'h0000_0004);
    rd("R2 ctrl rewrite", 8'h00, 32'h0000_0004);

    // R3 word writes
    wr(8'h08, 32'hA5A5_0001);
    wr(8'h0C, 32'h8000_0003);
    rd("R3 ren hi", 8'h08, 32'hA5A5_0001);
    rd("R3 ren lo", 8'h0C, 32'h8000_0003);
    chk("R3 req_en_o bits", req_en_o, 64'hA5A5_0001_8000_0003);
    wr(8'h10, 32'h0000_00F0);
    wr(8'h14, 32'h0000_0000);
    rd("R3 eie hi", 8'h10, 32'h0000_00F0);

    // R4 byte commands
    wr(8'h18, {8'd40, 8'd0, 8'd63, 8'd36}); // set ren 40, clr ren 0, set eie 63, clr eie 36
    rd("R4 ren hi after set", 8'h08, 32'hA5A5_0101);
    rd("R4 ren lo after clr", 8'h0C, 32'h8000_0002);
    rd("R4 eie hi", 8'h10, 32'h8000_00E0);
    wr(8'h18, {8'd5, 8'd5, 8'd0, 8'd0}, 4'b1100);  // same index set+clear
    rd("R4 clear wins", 8'h0C, 32'h8000_0002);
    wr(8'h18, {8'd9, 8'd1, 8'd0, 8'd0}, 4'b1000);  // lane 2 masked
    rd("R4 lane enable", 8'h0C, 32'h8000_0202);

    // R5 out of range indices
    wr(8'h18, {8'd64, 8'd200, 8'd127, 8'd255});
    wr(8'h1C, {8'd64, 8'd99, 8'd70, 8'd0});
    rd("R5 ren hi", 8'h08, m_rd(8'h08));
    rd("R5 ren lo", 8'h0C, 32'h8000_0202);
    rd("R5 eie hi", 8'h10, 32'h8000_00E0);
    chk("R5 no start", start_o, 0);

    // R6 pending bitmaps
    cyc(0, 0, 0, 0, 64'h0000_0010_0000_0081, 64'h0000_0000_0002_0008, 0, 0, 0);
    rd("R6 int lo", 8'h24, 32'h0000_0081);
    rd("R6 int hi", 8'h20, 32'h0000_0010);
    rd("R6 err lo", 8'h2C, 32'h0002_0008);
    wr(8'h24, 32'h0000_0001);
    rd("R6 w1c int", 8'h24, 32'h0000_0080);
    wr(8'h1C, {8'd36, 8'd0, 8'd0, 8'd0}, 4'b1000);
    rd("R6 clr int by index", 8'h20, 32'h0000_0000);
    cyc(1, 8'h24, 32'h0000_0080, 4'hF, 64'h80, 0, 0, 0, 0);  // set and w1c collide
    rd("R6 set wins", 8'h24, 32'h0000_0080);
    cyc(1, 8'h1C, {8'd7, 8'd0, 8'd0, 8'd0}, 4'b1000, 64'h80, 0, 0, 0, 0);
    rd("R6 set wins over index clr", 8'h24, 32'h0000_0080);

    // R7 interrupt aggregation
    chk("R7 irq from int", 64'(irq_o), 1);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    chk("R7 irq cleared", 64'(irq_o), 0);
    cyc(0, 0, 0, 0, 0, 64'h0000_0001_0000_0000, 0, 0, 0);  // ch32, eie off
    chk("R7 masked err", 64'(irq_o), 0);
    wr(8'h18, {8'd0, 8'd0, 8'd32, 8'd0}, 4'b0010);
    chk("R7 enabled err", 64'(irq_o), 1);
    wr(8'h28, 32'hFFFF_FFFF);
    chk("R7 err acked", 64'(irq_o), 0);

    // R8/R9 error latching
    cyc(0, 0, 0, 0, 0, 64'h2_0000, 1, 6'd17, 10'h3FF);
    rd("R8 first error", 8'h04, 32'h8000_D1FF);
    cyc(0, 0, 0, 0, 0, 64'h8, 1, 6'd3, 10'h001);
    rd("R9 second ignored", 8'h04, 32'h8000_D1FF);
    wr(8'h2C, 32'h0000_0008);
    rd("R9 other clear no effect", 8'h04, 32'h8000_D1FF);
    wr(8'h1C, {8'd0, 8'd17, 8'd0, 8'd0}, 4'b0100);
    rd("R9 released", 8'h04, 32'h0);
    cyc(0, 0, 0, 0, 0, 64'h200, 1, 6'd9, 10'h200);
    rd("R8 chan 9", 8'h04, 32'h8000_8900);
    cyc(1, 8'h2C, 32'h0000_0200, 4'hF, 0, 64'h40_0000, 1, 6'd22, 10'h001);
    rd("R9 clear with new error", 8'h04, 32'h8000_1601);

    // R10 start pulse
    @(negedge clk_i); #1;
    wr_i = 1; addr_i = 8'h1C; be_i = 4'b0010; wdata_i = {8'd0, 8'd0, 8'd45, 8'd0};
    @(negedge clk_i);
    chk("R10 pulse high", start_o, 64'h1 << 45);
    #1 wr_i = 0; be_i = 0;
    @(negedge clk_i);
    chk("R10 pulse one cycle", start_o, 0);

    // R11 status read
    hw_req_i = 64'h1234_5678_9ABC_DEF0;
    rd("R11 hw hi", 8'h30, 32'h1234_5678);
    rd("R11 hw lo", 8'h34, 32'h9ABC_DEF0);
    rd("R11 cmd reads 0", 8'h1C, 32'h0);
    rd("R11 unmapped", 8'h40, 32'h0);

    repeat (2) @(negedge clk_i);
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule